// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block is the synchronous write-side control for a byte-wide nonvolatile memory that a host writes as if it were an SRAM. The host pulses the chip and write enables while the output enable is high. Each valid pulse drops one byte into a page buffer. The address is taken when the combined strobe goes active. The data is taken when the strobe goes inactive again.

Bytes for one page may arrive in any order, and a byte may be rewritten before the page is committed. A load-window timer restarts with every accepted byte. When the window runs out, the controller presents the whole page to the array as one write request. It then stays busy for a fixed programming period and accepts nothing until that period ends. A byte mask shows which buffer slots were loaded, so the array updates only those bytes.

Writes are ignored for a power-on interval after reset. Strobes that are too short, or that occur while output enable is low, are also ignored. All durations are clock-count parameters.

Top module: `page_eeprom_wctl`

## Requirements
- R1: After reset, `busy`, `wr_req`, `wr_mask` and `page_err` are all 0.
- R2: A strobe that ends fewer than POR_CYC clock cycles after reset release loads nothing, and `busy` stays 0.
- R3: A valid write loads one byte and raises `busy`. A valid write needs `ce_n` and `we_n` both low for at least MIN_PULSE synchronised cycles, with `oe_n` high throughout.
- R4: The byte offset (address bits 7..0) and page (bits 18..8) are taken when the combined strobe becomes active. The data byte is taken when the strobe becomes inactive.
- R5: A strobe that is low for fewer than MIN_PULSE cycles is ignored.
- R6: A strobe during which `oe_n` is low is ignored.
- R7: When no byte has been accepted for LOAD_WIN cycles, `wr_req` pulses for one cycle. At that pulse, `wr_page` holds the page, `wr_mask` has bit k set for each loaded offset k, and `wr_data[8k+7:8k]` holds that byte.
- R8: Bytes may be loaded in any order. A repeated offset keeps its last value. Offsets that were never loaded stay 0 in `wr_mask`.
- R9: A byte whose page differs from the first byte's page is discarded and sets `page_err`. `page_err` stays set until reset.
- R10: `busy` stays high for exactly PROG_CYC cycles, counting from the `wr_req` cycle. Strobes during that time are ignored. `wr_mask` returns to 0 when `busy` falls.
- R11: Each accepted byte restarts the load window, so a page can keep loading for longer than LOAD_WIN in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte address: page in upper bits, offset in low OFF_W bits |
| din | input | DW | Write data bus |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low, asynchronous |
| busy | output | 1 | High from first accepted byte to end of programming |
| wr_req | output | 1 | One-cycle array write request |
| wr_page | output | AW-OFF_W | Page being committed |
| wr_data | output | PAGE_N*DW | Page buffer contents, offset k at bits 8k+7:8k |
| wr_mask | output | PAGE_N | Loaded-byte mask, bit k for offset k |
| page_err | output | 1 | Sticky flag: a byte for another page was discarded |

## Verification
A single byte is loaded with a pulse of exactly the minimum width. This separates correct acceptance from an off-by-one in the width filter, and a strobe one cycle shorter must be rejected. A multi-byte load with scattered offsets and one repeated offset shows that the last value wins and that the mask is exact. Another load changes address and data in the middle of the pulse, which shows which strobe edge captures each of them. Three bytes spread over more than one window show that the window restarts, and a second-page byte tests the discard path. Strobes that arrive during the power-on delay, during programming, or with output enable low must leave `busy` low.

// File: rtl/page_eeprom_wctl.sv
module page_eeprom_wctl #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int OFF_W     = 8,
  parameter int MIN_PULSE = 3,
  parameter int LOAD_WIN  = 40,
  parameter int PROG_CYC  = 60,
  parameter int POR_CYC   = 30,
  localparam int PAGE_N   = 1 << OFF_W,
  localparam int PG_W     = AW - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        din,
  input  logic                 ce_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  output logic                 busy,
  output logic                 wr_req,
  output logic [PG_W-1:0]      wr_page,
  output logic [PAGE_N*DW-1:0] wr_data,
  output logic [PAGE_N-1:0]    wr_mask,
  output logic                 page_err
);
  localparam int TMAX = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POR_CYC + 1);
  localparam int LW   = $clog2(MIN_PULSE + 1);

  typedef enum logic [1:0] {IDLE, LOAD, PROG} st_t;

  st_t              st;
  logic [2:0]       str_q;
  logic [1:0]       oe_q;
  logic [LW-1:0]    lo_cnt;
  logic             oe_ok;
  logic [AW-1:0]    addr_q;
  logic [PW-1:0]    por_cnt;
  logic [TW-1:0]    tmr;
  logic [PG_W-1:0]  page_q;
  logic [PAGE_N-1:0] mask_q;
  logic [DW-1:0]    buf_q [PAGE_N];

  wire fall     = !str_q[1] && str_q[2];
  wire rise     = str_q[1] && !str_q[2];
  wire por_done = (por_cnt == PW'(POR_CYC));
  wire [OFF_W-1:0] off = addr_q[OFF_W-1:0];
  wire [PG_W-1:0]  pg  = addr_q[AW-1:OFF_W];
  wire same_pg  = (pg == page_q);
  wire accept   = rise && (lo_cnt >= LW'(MIN_PULSE)) && oe_ok && oe_q[1]
                  && por_done && (st != PROG);
  wire store    = accept && ((st == IDLE) || same_pg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q   <= '1;
      oe_q    <= '1;
      lo_cnt  <= '0;
      oe_ok   <= 1'b0;
      addr_q  <= '0;
      por_cnt <= '0;
    end else begin
      str_q <= {str_q[1:0], ~(~ce_n & ~we_n)};
      oe_q  <= {oe_q[0], oe_n};
      if (!por_done) por_cnt <= por_cnt + 1'b1;
      if (fall) begin
        lo_cnt <= LW'(1);
        oe_ok  <= oe_q[1];
        addr_q <= addr;
      end else if (!str_q[1]) begin
        if (lo_cnt < LW'(MIN_PULSE)) lo_cnt <= lo_cnt + 1'b1;
        oe_ok <= oe_ok & oe_q[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      tmr      <= '0;
      page_q   <= '0;
      mask_q   <= '0;
      wr_req   <= 1'b0;
      page_err <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          page_q      <= pg;
          mask_q      <= '0;
          mask_q[off] <= 1'b1;
          tmr         <= '0;
          st          <= LOAD;
        end
        LOAD: if (store) begin
          mask_q[off] <= 1'b1;
          tmr         <= '0;
        end else begin
          if (accept) page_err <= 1'b1;
          if (tmr == TW'(LOAD_WIN - 1)) begin
            tmr    <= '0;
            wr_req <= 1'b1;
            st     <= PROG;
          end else tmr <= tmr + 1'b1;
        end
        PROG: if (tmr == TW'(PROG_CYC - 1)) begin
          mask_q <= '0;
          st     <= IDLE;
        end else tmr <= tmr + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (store) buf_q[off] <= din;

  assign busy    = (st != IDLE);
  assign wr_page = page_q;
  assign wr_mask = mask_q;

  for (genvar k = 0; k < PAGE_N; k++) begin : g_out
    assign wr_data[k*DW +: DW] = buf_q[k];
  end
endmodule

// File: rtl/page_eeprom_wctl_chk.sv
module page_eeprom_wctl_chk #(
  parameter int PAGE_N  = 256,
  parameter int POR_CYC = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_req,
  input logic [PAGE_N-1:0] wr_mask,
  input logic              page_err
);
  localparam int PW = $clog2(POR_CYC + 1);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != PW'(POR_CYC)) cnt <= cnt + 1'b1;

  a_r2_idle_during_por: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < PW'(POR_CYC)) |-> !busy);
  a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);
  a_r7_req_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_mask != '0));
  a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  a_r10_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wr_mask == '0));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
endmodule

bind page_eeprom_wctl page_eeprom_wctl_chk #(.PAGE_N(PAGE_N), .POR_CYC(POR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_req(wr_req),
  .wr_mask(wr_mask), .page_err(page_err)
);

// File: tb/page_eeprom_wctl_bench.sv
module page_eeprom_wctl_bench;
  localparam int CLK_P = 10;
  localparam int AW = 19, DW = 8, OFF_W = 8, PAGE_N = 256, PG_W = 11;
  localparam int MIN_PULSE = 3, LOAD_WIN = 40, PROG_CYC = 60, POR_CYC = 30;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic busy, wr_req, page_err;
  logic [PG_W-1:0] wr_page;
  logic [PAGE_N*DW-1:0] wr_data;
  logic [PAGE_N-1:0] wr_mask;
  int total = 0, bad = 0;
  bit seen;

  always #(CLK_P/2) clk = ~clk;

  page_eeprom_wctl #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .MIN_PULSE(MIN_PULSE),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC)) u_page_eeprom_wctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .busy(busy), .wr_req(wr_req), .wr_page(wr_page), .wr_data(wr_data),
    .wr_mask(wr_mask), .page_err(page_err));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, int lo, logic oe);
    @(negedge clk); addr = a; din = d; oe_n = oe; ce_n = 0;
    @(negedge clk); we_n = 0;
    repeat (lo) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_req();
    seen = 0;
    for (int i = 0; i < 500 && !seen; i++) begin
      @(negedge clk);
      if (wr_req) seen = 1;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] byte_at(int k);
    return wr_data[k*8 +: 8];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 wr_req", wr_req, 0);
    chk("R1 mask", wr_mask, 0); chk("R1 page_err", page_err, 0);
  endtask

  task automatic t_por();
    wr(19'h00011, 8'h5A, 6, 1);
    repeat (10) @(negedge clk);
    chk("R2 write during power-on delay ignored", busy, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_single();
    int n;
    wr(19'h12345, 8'hA5, MIN_PULSE, 1);
    repeat (4) @(negedge clk);
    chk("R3 busy after minimum-width write", busy, 1);
    wait_req();
    chk("R7 request issued", seen, 1);
    chk("R7 page", wr_page, 11'h123);
    chk("R7 mask one byte", $countones(wr_mask), 1);
    chk("R7 mask bit", wr_mask[8'h45], 1);
    chk("R7 data", byte_at(8'h45), 8'hA5);
    n = 0;
    while (busy && n < 500) begin n++; @(negedge clk); end
    chk("R10 programming length", n, PROG_CYC);
    chk("R10 mask cleared", wr_mask, 0);
  endtask

  task automatic t_short();
    wr(19'h00100, 8'h01, MIN_PULSE - 1, 1);
    repeat (60) @(negedge clk);
    chk("R5 short strobe ignored", busy, 0);
  endtask

  task automatic t_oe();
    wr(19'h00200, 8'h02, 6, 0);
    repeat (60) @(negedge clk);
    chk("R6 output enable low inhibits", busy, 0);
  endtask

  task automatic t_edges();
    @(negedge clk); addr = 19'h03010; din = 8'h11; oe_n = 1; ce_n = 0;
    @(negedge clk); we_n = 0;
    repeat (4) @(negedge clk);
    addr = 19'h03020; din = 8'h99;
    repeat (3) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1;
    wait_req();
    chk("R4 address from strobe start", wr_mask[8'h10], 1);
    chk("R4 later address unused", wr_mask[8'h20], 0);
    chk("R4 data from strobe end", byte_at(8'h10), 8'h99);
    wait_idle();
  endtask

  task automatic t_order();
    wr(19'h07F10, 8'h11, 4, 1);
    wr(19'h07F02, 8'h22, 4, 1);
    wr(19'h07F10, 8'h33, 4, 1);
    wr(19'h07FFF, 8'h44, 4, 1);
    wait_req();
    chk("R8 request", seen, 1);
    chk("R8 mask count", $countones(wr_mask), 3);
    chk("R8 mask bits", {wr_mask[8'h02], wr_mask[8'h10], wr_mask[8'hFF]}, 3'b111);
    chk("R8 overwrite last wins", byte_at(8'h10), 8'h33);
    chk("R8 byte 02", byte_at(8'h02), 8'h22);
    chk("R8 byte FF", byte_at(8'hFF), 8'h44);
    wait_idle();
  endtask

  task automatic t_window();
    wr(19'h05001, 8'h01, 4, 1);
    repeat (20) @(negedge clk);
    wr(19'h05002, 8'h02, 4, 1);
    repeat (20) @(negedge clk);
    wr(19'h05003, 8'h03, 4, 1);
    wait_req();
    chk("R11 window restarts, all bytes kept", $countones(wr_mask), 3);
    chk("R11 last byte", byte_at(3), 8'h03);
    wait_idle();
  endtask

  task automatic t_prog_block();
    wr(19'h20000, 8'h77, 4, 1);
    wait_req();
    wr(19'h20005, 8'h88, 6, 1);
    chk("R10 busy during programming", busy, 1);
    wait_idle();
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy || wr_req) seen = 1;
    end
    chk("R10 write during programming ignored", seen, 0);
  endtask

  task automatic t_page();
    wr(19'h11105, 8'h55, 4, 1);
    wr(19'h22206, 8'h66, 4, 1);
    chk("R9 page error set", page_err, 1);
    wait_req();
    chk("R9 foreign byte discarded", wr_mask[6], 0);
    chk("R9 first byte kept", wr_mask[5], 1);
    chk("R9 page kept", wr_page, 11'h111);
    wait_idle();
    chk("R9 page error sticky", page_err, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_por();
    t_single();
    t_short();
    t_oe();
    t_edges();
    t_order();
    t_window();
    t_prog_block();
    t_page();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule